// File: doc/BRIEF.md
# Serial Outer Bank Register with Save-RAM Routing

This block sits on the cartridge side of a CPU bus, next to an inner bank controller that handles the fine-grained banking. It adds an outer bank selection on top of that controller. The CPU programs the block by writing into a 4 KiB address window. Each write carries a single bit on data line 3. After four such writes, the collected nibble becomes the active outer bank value.

The active value has three jobs. It supplies the top three program-ROM address lines. It raises a flag that tells game-play apart from the menu. It also decides how the save-RAM lines are wired to two 32 KiB battery-backed chips.

- When bit 1 is clear, chip #1 is in use. Its A13 line follows the inner controller's CHR A15 output, and its A14 line follows bit 0.
- When bit 1 is set, chip #2 is in use. The CHR A15 output is then ignored. Bit 0 drives the chip's A13 line and bit 2 drives its A14 line.

A chip select is raised only for an access in the CPU RAM window while the inner controller's RAM enable is active. Every output is registered.

Top module: `serial_outer_bank`

## Requirements
- R1: A write counts toward the serial load only when cpu_wr is high and cpu_addr[15:12] equals 4'h5. Writes at any other address leave the load sequence and all outputs unchanged.
- R2: Each counted write supplies the bit on cpu_data[3]. The first bit lands in outer bit 0 and the fourth lands in bit 3.
- R3: The active outer value changes only at the clock edge that samples the fourth counted write of a group. The count then restarts. rom_hi stays steady across the first three writes of a group.
- R4: Data bit 7 has no reset effect. A counted write with cpu_data[7]=1 is treated as an ordinary serial bit.
- R5: A synchronous reset clears the active value and the write count. After reset, rom_hi=3'b000, game_mode=0 and both chip selects are 0.
- R6: A chip select rises one cycle after a cycle in which ram_win and ram_en are both 1. In every other case both chip selects are 0.
- R7: ram_cs1 and ram_cs2 are never 1 at the same time.
- R8: Outer bit 1 chooses the chip: 0 selects ram_cs1 and 1 selects ram_cs2. It also drives rom_hi[1] (ROM A19).
- R9: Outer bit 0 drives rom_hi[0] (A18), ram1_a14 and ram2_a13. Outer bit 2 drives rom_hi[2] (A20) and ram2_a14. ram1_a13 is inner_chr_a15 registered by one cycle.
- R10: game_mode equals outer bit 3. A value of 1 means game-play and 0 means menu.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU-side clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| cpu_addr | input | 16 | CPU address |
| cpu_data | input | 8 | CPU write data |
| cpu_wr | input | 1 | One-cycle write strobe |
| inner_chr_a15 | input | 1 | CHR A15 output of the inner controller |
| ram_win | input | 1 | CPU access to the 8 KiB RAM window |
| ram_en | input | 1 | RAM enable from the inner controller |
| rom_hi | output | 3 | ROM A20..A18 (bit 0 is A18) |
| game_mode | output | 1 | 1 during game-play, 0 in the menu |
| ram_cs1 | output | 1 | Chip select for RAM chip #1 |
| ram_cs2 | output | 1 | Chip select for RAM chip #2 |
| ram1_a13 | output | 1 | RAM chip #1 A13 |
| ram1_a14 | output | 1 | RAM chip #1 A14 |
| ram2_a13 | output | 1 | RAM chip #2 A13 |
| ram2_a14 | output | 1 | RAM chip #2 A14 |

## Verification
The hardest state to reach from the ports is a load sequence that is partly filled. In that state the write count is hidden and only rom_hi shows its effect, and even then only after a whole group of four. The stimulus therefore interleaves writes outside the window, writes with data bit 7 set, and RAM accesses in the middle of a group. The next commit then shows whether any of these shifted the group boundary. A long random phase follows and keeps the groups misaligned with the other traffic.

// File: rtl/obr_pkg.sv
package obr_pkg;
  localparam int OUTER_W = 4;

  // Decoded view of the active outer value; field order follows bit order.
  typedef struct packed {
    logic game;
    logic a20;
    logic chip2;
    logic a18;
  } outer_t;
endpackage

// File: rtl/obr_serial_loader.sv
module obr_serial_loader #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int OUTER_W = 4,
  parameter int SER_BIT = 3,
  parameter int DEC_W   = 4,
  parameter int WIN_ID  = 5
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [ADDR_W-1:0]  cpu_addr,
  input  logic [DATA_W-1:0]  cpu_data,
  input  logic               cpu_wr,
  output logic [OUTER_W-1:0] outer_q
);
  localparam int CNT_W = (OUTER_W > 1) ? $clog2(OUTER_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OUTER_W - 1);

  logic [OUTER_W-1:0] shift_q;
  logic [OUTER_W-1:0] shift_nxt;
  logic [CNT_W-1:0]   cnt_q;
  logic               hit;

  assign hit       = cpu_wr && (cpu_addr[ADDR_W-1 -: DEC_W] == DEC_W'(WIN_ID));
  // least significant bit arrives first, so new bits enter at the top
  assign shift_nxt = {cpu_data[SER_BIT], shift_q[OUTER_W-1:1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      cnt_q   <= '0;
      outer_q <= '0;
    end else if (hit) begin
      shift_q <= shift_nxt;
      if (cnt_q == LAST) begin
        cnt_q   <= '0;
        outer_q <= shift_nxt;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/obr_ram_router.sv
module obr_ram_router
  import obr_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  outer_t outer,
  input  logic   inner_chr_a15,
  input  logic   ram_win,
  input  logic   ram_en,
  output logic   ram_cs1,
  output logic   ram_cs2,
  output logic   ram1_a13,
  output logic   ram1_a14,
  output logic   ram2_a13,
  output logic   ram2_a14
);
  logic access;
  assign access = ram_win && ram_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_cs1  <= 1'b0;
      ram_cs2  <= 1'b0;
      ram1_a13 <= 1'b0;
    end else begin
      ram_cs1  <= access && !outer.chip2;
      ram_cs2  <= access &&  outer.chip2;
      ram1_a13 <= inner_chr_a15;
    end
  end

  // outer is itself a register, so these lines are registered outputs
  assign ram1_a14 = outer.a18;
  assign ram2_a13 = outer.a18;
  assign ram2_a14 = outer.a20;
endmodule

// File: rtl/serial_outer_bank.sv
module serial_outer_bank
  import obr_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int SER_BIT = 3,
  parameter int DEC_W   = 4,
  parameter int WIN_ID  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_data,
  input  logic              cpu_wr,
  input  logic              inner_chr_a15,
  input  logic              ram_win,
  input  logic              ram_en,
  output logic [2:0]        rom_hi,
  output logic              game_mode,
  output logic              ram_cs1,
  output logic              ram_cs2,
  output logic              ram1_a13,
  output logic              ram1_a14,
  output logic              ram2_a13,
  output logic              ram2_a14
);
  logic [OUTER_W-1:0] outer_raw;
  outer_t             outer;

  obr_serial_loader #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .OUTER_W(OUTER_W),
    .SER_BIT(SER_BIT),
    .DEC_W  (DEC_W),
    .WIN_ID (WIN_ID)
  ) u_loader (
    .clk     (clk),
    .rst     (rst),
    .cpu_addr(cpu_addr),
    .cpu_data(cpu_data),
    .cpu_wr  (cpu_wr),
    .outer_q (outer_raw)
  );

  assign outer     = outer_t'(outer_raw);
  assign rom_hi    = {outer.a20, outer.chip2, outer.a18};
  assign game_mode = outer.game;

  obr_ram_router u_router (
    .clk          (clk),
    .rst          (rst),
    .outer        (outer),
    .inner_chr_a15(inner_chr_a15),
    .ram_win      (ram_win),
    .ram_en       (ram_en),
    .ram_cs1      (ram_cs1),
    .ram_cs2      (ram_cs2),
    .ram1_a13     (ram1_a13),
    .ram1_a14     (ram1_a14),
    .ram2_a13     (ram2_a13),
    .ram2_a14     (ram2_a14)
  );
endmodule

// File: rtl/obr_checker.sv
module obr_checker (
  input logic        clk,
  input logic        rst,
  input logic [15:0] cpu_addr,
  input logic        cpu_wr,
  input logic        ram_win,
  input logic        ram_en,
  input logic [2:0]  rom_hi,
  input logic        game_mode,
  input logic        ram_cs1,
  input logic        ram_cs2
);
  logic in_window;
  assign in_window = cpu_wr && (cpu_addr[15:12] == 4'h5);

  // R3
  rom_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(in_window) |-> ($stable(rom_hi) && $stable(game_mode)));

  // R5
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rom_hi == 3'b000 && !game_mode && !ram_cs1 && !ram_cs2));

  // R6
  cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (ram_cs1 || ram_cs2) |-> $past(ram_win && ram_en));

  // R7
  one_chip_chk: assert property (@(posedge clk) disable iff (rst)
    $countones({ram_cs1, ram_cs2}) <= 1);

  // R8
  chip2_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ram_cs2 |-> $past(rom_hi[1]));

  // R8
  chip1_sel_chk: assert property (@(posedge clk) disable iff (rst)
    ram_cs1 |-> !$past(rom_hi[1]));
endmodule

bind serial_outer_bank obr_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpu_addr (cpu_addr),
  .cpu_wr   (cpu_wr),
  .ram_win  (ram_win),
  .ram_en   (ram_en),
  .rom_hi   (rom_hi),
  .game_mode(game_mode),
  .ram_cs1  (ram_cs1),
  .ram_cs2  (ram_cs2)
);

// File: tb/test_serial_outer_bank.sv
`timescale 1ns/1ps
module test_serial_outer_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_wr = 1'b0;
  logic        inner_chr_a15 = 1'b0;
  logic        ram_win = 1'b0;
  logic        ram_en = 1'b0;
  logic [2:0]  rom_hi;
  logic        game_mode, ram_cs1, ram_cs2;
  logic        ram1_a13, ram1_a14, ram2_a13, ram2_a14;

  int vectors = 0;
  int misses  = 0;

  always #10 clk = ~clk;

  serial_outer_bank i_serial_outer_bank (
    .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .cpu_wr(cpu_wr), .inner_chr_a15(inner_chr_a15), .ram_win(ram_win),
    .ram_en(ram_en), .rom_hi(rom_hi), .game_mode(game_mode),
    .ram_cs1(ram_cs1), .ram_cs2(ram_cs2), .ram1_a13(ram1_a13),
    .ram1_a14(ram1_a14), .ram2_a13(ram2_a13), .ram2_a14(ram2_a14)
  );

  // Behavioural reference model
  bit      pend[$];
  int      m_val = 0;
  bit      m_cs1 = 0, m_cs2 = 0, m_a13 = 0;

  always @(posedge clk) begin
    if (rst) begin
      pend.delete();
      m_val = 0; m_cs1 = 0; m_cs2 = 0; m_a13 = 0;
    end else begin
      m_cs1 = ram_win && ram_en && (((m_val >> 1) & 1) == 0);
      m_cs2 = ram_win && ram_en && (((m_val >> 1) & 1) == 1);
      m_a13 = inner_chr_a15;
      if (cpu_wr && cpu_addr >= 16'h5000 && cpu_addr <= 16'h5FFF) begin
        pend.push_back(cpu_data[3]);
        if (pend.size() == 4) begin
          m_val = 0;
          for (int k = 0; k < 4; k++) m_val += int'(pend[k]) << k;
          pend.delete();
        end
      end
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    chk("R8",  "rom_hi[1]", rom_hi[1], (m_val >> 1) & 1);
    chk("R9",  "rom_hi[0]", rom_hi[0], m_val & 1);
    chk("R9",  "rom_hi[2]", rom_hi[2], (m_val >> 2) & 1);
    chk("R10", "game_mode", game_mode, (m_val >> 3) & 1);
    chk("R6",  "ram_cs1", ram_cs1, m_cs1);
    chk("R6",  "ram_cs2", ram_cs2, m_cs2);
    chk("R7",  "cs pair", ram_cs1 & ram_cs2, 0);
    chk("R9",  "ram1_a13", ram1_a13, m_a13);
    chk("R9",  "ram1_a14", ram1_a14, m_val & 1);
    chk("R9",  "ram2_a13", ram2_a13, m_val & 1);
    chk("R9",  "ram2_a14", ram2_a14, (m_val >> 2) & 1);
  endtask

  task automatic step(logic [15:0] a, logic [7:0] d, logic w, logic c, logic rw, logic re);
    cpu_addr = a; cpu_data = d; cpu_wr = w;
    inner_chr_a15 = c; ram_win = rw; ram_en = re;
    @(negedge clk);
    compare_all();
  endtask

  task automatic load(logic [3:0] v, logic [15:0] a);
    for (int i = 0; i < 4; i++) step(a, {4'h0, v[i], 3'b101}, 1'b1, 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    misses++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk); @(negedge clk);
    rst = 1'b0;
    // R5: reset state
    step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R5", "rom_hi after reset", rom_hi, 0);
    chk("R5", "game_mode after reset", game_mode, 0);
    chk("R6", "cs1 with menu value", ram_cs1, 1);

    // R2, R10: load 4'hA (game, chip2, A20=0, A18=0)
    load(4'hA, 16'h5000);
    chk("R2", "value A", {game_mode, rom_hi}, 4'hA);
    chk("R10", "game flag", game_mode, 1);

    // R1: outside-window writes mid-group; R3: hold through partial group
    step(16'h5FFF, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0);
    step(16'h4FFF, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0);
    step(16'h6000, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0);
    step(16'h5123, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R3", "hold after partial group", rom_hi, 3'b010);
    // R4: bit 7 set is just a data bit
    step(16'h5800, 8'h80, 1'b1, 1'b0, 1'b0, 1'b0);
    step(16'h5000, 8'h88, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R3", "no commit before fourth", rom_hi, 3'b010);
    step(16'h5A00, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0);
    chk("R4", "commit value 4'hD", {game_mode, rom_hi}, 4'hD);
    chk("R1", "outside writes not counted", {game_mode, rom_hi}, 4'hD);

    // R8, R9: chip1 routing with chr_a15 toggling
    load(4'h9, 16'h5555);
    step(16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8", "chip1 selected", ram_cs1, 1);
    chk("R9", "chip1 a13 follows chr", ram1_a13, 1);
    step(16'h0000, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R6", "no select without enable", ram_cs1 | ram_cs2, 0);
    load(4'hF, 16'h5001);
    step(16'h0000, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R8", "chip2 selected", ram_cs2, 1);
    chk("R9", "chip2 a14", ram2_a14, 1);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      a = ($urandom % 2) ? {4'h5, 12'($urandom)} : 16'($urandom);
      step(a, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R5: reset mid-group clears the count
    step(16'h5000, 8'h08, 1'b1, 1'b0, 1'b0, 1'b0);
    rst = 1'b1;
    @(negedge clk); @(negedge clk);
    rst = 1'b0;
    load(4'h6, 16'h5000);
    chk("R5", "count cleared by reset", {game_mode, rom_hi}, 4'h6);

    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule